// File: doc/BRIEF.md
# Flash Buffered-Program Sequencer

This block is a command-level controller for a flash device's buffered program operation. A host issues writes over one bus port. The first write is a setup command sent to the target erase block. Next comes a word count, then a start address carrying the first data word, then the remaining address/data pairs, which go into an internal 32-entry buffer. The last write is a confirm command. The sequencer then copies the buffered words into an on-chip array model over a timed busy period. It reports ready/busy and error conditions in an 8-bit status byte.

The write port uses valid/ready. `wr_ready` is low for the whole busy period. A host holding `wr_valid` high keeps its address and data stable until a cycle in which `wr_ready` is high; the write is taken on that clock edge. While the block is not busy, `wr_ready` stays high, so every write is taken in the cycle it is offered. The status byte, the supply-lock input, the cell-fault input and the clear-status input are plain level signals. The array can be read at any time through a combinational read port.

Status bit 7 is ready (1) or busy (0). Bit 5 flags a sequence or range error. Bit 4 flags a program error. Bit 3 flags a supply lockout. All other bits read 0. Command codes are taken from the low byte of `wr_data` and are parameters: setup 0xE8, confirm 0xD0, clear 0x50. The count write carries the number of words minus one in `wr_data[4:0]`.

Top module: `flash_bufprog_seq`

## Requirements
- R1: After reset, status reads 0x80, `wr_ready` is 1, and every array word reads 0xFFFF.
- R2: A full sequence stores each buffered word at its own address. The sequence is: setup (0xE8) to any address in an erase block, then a count n-1 in `wr_data[4:0]`, then n address/data writes inside [start, start+n-1], then confirm (0xD0) to an address in the same 128-word erase block. Afterwards status returns to 0x80, and a new setup may begin another sequence.
- R3: Status bit 7 reads 0 and `wr_ready` reads 0 for exactly T_CHUNK cycles, beginning the cycle after the confirm write is accepted. The time doubles to 2*T_CHUNK when start and start+n-1 lie in different 32-word aligned chunks.
- R4: In the fill phase, a data write whose address lies outside [start, start+n-1] sets bits 5 and 4 (status 0xB0). The sequence ends and the array is left unchanged.
- R5: At the confirm step, a write whose low byte is not 0xD0, or whose address lies outside the setup erase block, sets status 0xB0. Nothing is programmed.
- R6: If start+n-1 falls in a different erase block than start (or past the top of the array), the first data write aborts the sequence with status 0xB0. The array is left unchanged.
- R7: A setup command accepted while `supply_lock` is 1 sets bits 4 and 3 (status 0x98) and starts no sequence. Writes that follow, up to the next setup, change neither the array nor the status.
- R8: If `cell_fault` is 1 in the cycle a word is due to be programmed, that word and all later words are left unchanged, and bit 4 is set (status 0x90). The block turns ready in the next cycle, so busy lasts j+1 cycles when word j faults.
- R9: Bits 5, 4 and 3 stay set through later successful programs. They clear only on a 0x50 command written while idle, or on a cycle with `clr_status` at 1.
- R10: When two fill writes hit the same address, the later data wins. A buffer slot that no write filled leaves its array word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus write offered |
| wr_ready | output | 1 | Write accepted on this edge if valid (low while busy) |
| wr_addr | input | AW (8) | Word address of the write |
| wr_data | input | DW (16) | Command in low byte, count, or data word |
| supply_lock | input | 1 | Programming supply below lockout level |
| cell_fault | input | 1 | Array write of the current word fails |
| clr_status | input | 1 | Clear error bits 5, 4 and 3 |
| status | output | 8 | Ready and error flags |
| rd_addr | input | AW (8) | Array read address |
| rd_data | output | DW (16) | Array word at rd_addr |

## Verification
Every accepted write updates state and status on the edge where it is taken, so the bench checks status at the falling edge right after the write completes. It also checks the array read port there after a completed or aborted sequence. Busy time is measured by counting falling edges with status bit 7 low, starting at the first falling edge after the confirm edge. That count is compared to T_CHUNK, 2*T_CHUNK or j+1 as computed by bench functions. Faults are injected by raising `cell_fault` before the edge at which word j is due, which is the (j+1)-th edge after confirm.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_COUNT, S_FIRST, S_FILL, S_CONFIRM, S_PROG
  } seq_state_t;

  localparam int SR_READY = 7;
  localparam int SR_SEQ   = 5;
  localparam int SR_PGM   = 4;
  localparam int SR_LOCK  = 3;
endpackage

// File: rtl/fbp_wbuf.sv
module fbp_wbuf #(
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  parameter int BW        = $clog2(BUF_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          we,
  input  logic [BW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] ridx,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0]        slot_q [BUF_WORDS];
  logic [BUF_WORDS-1:0] fill_q;

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
        fill_q[g] <= 1'b0;
      end else if (clr) begin
        fill_q[g] <= 1'b0;
      end else if (we && widx == BW'(g)) begin
        slot_q[g] <= wdata;
        fill_q[g] <= 1'b1;
      end
    end
  end

  assign rdata  = slot_q[ridx];
  assign rvalid = fill_q[ridx];

  p_clr_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (fill_q == '0));
endmodule

// File: rtl/fbp_array.sv
module fbp_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int WORDS = 1 << AW;
  logic [DW-1:0] cell_q [WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) cell_q[i] <= '1;
    end else if (we) begin
      cell_q[waddr] <= wdata;
    end
  end

  assign rdata = cell_q[raddr];
endmodule

// File: rtl/fbp_timer.sv
module fbp_timer #(
  parameter int T_CHUNK = 40,
  parameter int TW      = $clog2(2 * T_CHUNK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dbl,
  input  logic          abort,
  output logic          running,
  output logic [TW-1:0] cnt,
  output logic          done
);
  logic [TW-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      limit_q <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      limit_q <= dbl ? TW'(2 * T_CHUNK - 1) : TW'(T_CHUNK - 1);
    end else if (running) begin
      if (abort || cnt == limit_q) running <= 1'b0;
      else                          cnt     <= cnt + 1'b1;
    end
  end

  assign done = running && (cnt == limit_q);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= limit_q));
  p_run_ends_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> !running);
endmodule

// File: rtl/flash_bufprog_seq.sv
module flash_bufprog_seq
  import fbp_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          DW          = 16,
  parameter int          BUF_WORDS   = 32,
  parameter int          BLK_WORDS   = 128,
  parameter int          T_CHUNK     = 40,
  parameter logic [7:0]  CMD_SETUP   = 8'hE8,
  parameter logic [7:0]  CMD_CONFIRM = 8'hD0,
  parameter logic [7:0]  CMD_CLEAR   = 8'h50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          supply_lock,
  input  logic          cell_fault,
  input  logic          clr_status,
  output logic [7:0]    status,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int BW   = $clog2(BUF_WORDS);
  localparam int CW   = BW + 1;
  localparam int BLKB = $clog2(BLK_WORDS);
  localparam int TW   = $clog2(2 * T_CHUNK);
  localparam int AW1  = AW + 1;

  seq_state_t      state_q;
  logic [AW-BLKB-1:0] blk_q;
  logic [AW-1:0]   start_q;
  logic [CW-1:0]   count_q;
  logic [CW-1:0]   left_q;
  logic            chunk_q;
  logic            sr_seq_q, sr_pgm_q, sr_lock_q;

  logic            hs;
  logic [7:0]      cmd;
  logic [AW-1:0]   offs;
  logic            in_win;
  logic [AW:0]     end_addr;
  logic            blk_cross, chunk_cross;
  logic            confirm_ok;

  logic            buf_clr, buf_we;
  logic [BW-1:0]   buf_widx;
  logic [DW-1:0]   buf_rdata;
  logic            buf_rvalid;

  logic            tmr_start, tmr_run, tmr_done;
  logic [TW-1:0]   tmr_cnt;
  logic            word_due, fault, arr_we;
  logic [AW-1:0]   arr_waddr;

  assign wr_ready = (state_q != S_PROG);
  assign hs       = wr_valid && wr_ready;
  assign cmd      = wr_data[7:0];

  // Fill-window and range checks
  assign offs        = wr_addr - start_q;
  assign in_win      = 32'(offs) < 32'(count_q);
  assign end_addr    = {1'b0, wr_addr} + AW1'(count_q) - AW1'(1);
  assign blk_cross   = end_addr[AW:BLKB] != {1'b0, wr_addr[AW-1:BLKB]};
  assign chunk_cross = end_addr[AW:BW]   != {1'b0, wr_addr[AW-1:BW]};
  assign confirm_ok  = (cmd == CMD_CONFIRM) && (wr_addr[AW-1:BLKB] == blk_q);

  // Buffer control
  assign buf_clr  = hs && state_q == S_IDLE && cmd == CMD_SETUP && !supply_lock;
  assign buf_we   = hs && ((state_q == S_FIRST && !blk_cross) ||
                           (state_q == S_FILL  && in_win));
  assign buf_widx = (state_q == S_FIRST) ? '0 : offs[BW-1:0];

  fbp_wbuf #(.DW(DW), .BUF_WORDS(BUF_WORDS), .BW(BW)) u_wbuf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (buf_clr),
    .we    (buf_we),
    .widx  (buf_widx),
    .wdata (wr_data),
    .ridx  (tmr_cnt[BW-1:0]),
    .rdata (buf_rdata),
    .rvalid(buf_rvalid)
  );

  // Program phase
  assign tmr_start = hs && state_q == S_CONFIRM && confirm_ok;
  assign word_due  = tmr_run && (32'(tmr_cnt) < 32'(count_q)) && buf_rvalid;
  assign fault     = word_due && cell_fault;
  assign arr_we    = word_due && !cell_fault;
  assign arr_waddr = start_q + AW'(tmr_cnt);

  fbp_timer #(.T_CHUNK(T_CHUNK), .TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (tmr_start),
    .dbl    (chunk_q),
    .abort  (fault),
    .running(tmr_run),
    .cnt    (tmr_cnt),
    .done   (tmr_done)
  );

  fbp_array #(.AW(AW), .DW(DW)) u_array (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (arr_we),
    .waddr(arr_waddr),
    .wdata(buf_rdata),
    .raddr(rd_addr),
    .rdata(rd_data)
  );

  // Command sequencer and status flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      blk_q     <= '0;
      start_q   <= '0;
      count_q   <= '0;
      left_q    <= '0;
      chunk_q   <= 1'b0;
      sr_seq_q  <= 1'b0;
      sr_pgm_q  <= 1'b0;
      sr_lock_q <= 1'b0;
    end else begin
      if (clr_status) begin
        sr_seq_q  <= 1'b0;
        sr_pgm_q  <= 1'b0;
        sr_lock_q <= 1'b0;
      end
      unique case (state_q)
        S_IDLE: if (hs) begin
          if (cmd == CMD_SETUP) begin
            if (supply_lock) begin
              sr_pgm_q  <= 1'b1;
              sr_lock_q <= 1'b1;
            end else begin
              blk_q   <= wr_addr[AW-1:BLKB];
              state_q <= S_COUNT;
            end
          end else if (cmd == CMD_CLEAR) begin
            sr_seq_q  <= 1'b0;
            sr_pgm_q  <= 1'b0;
            sr_lock_q <= 1'b0;
          end
        end
        S_COUNT: if (hs) begin
          count_q <= CW'(wr_data[BW-1:0]) + CW'(1);
          state_q <= S_FIRST;
        end
        S_FIRST: if (hs) begin
          if (blk_cross) begin
            sr_seq_q <= 1'b1;
            sr_pgm_q <= 1'b1;
            state_q  <= S_IDLE;
          end else begin
            start_q <= wr_addr;
            chunk_q <= chunk_cross;
            left_q  <= count_q - CW'(1);
            state_q <= (count_q == CW'(1)) ? S_CONFIRM : S_FILL;
          end
        end
        S_FILL: if (hs) begin
          if (!in_win) begin
            sr_seq_q <= 1'b1;
            sr_pgm_q <= 1'b1;
            state_q  <= S_IDLE;
          end else begin
            left_q <= left_q - CW'(1);
            if (left_q == CW'(1)) state_q <= S_CONFIRM;
          end
        end
        S_CONFIRM: if (hs) begin
          if (confirm_ok) begin
            state_q <= S_PROG;
          end else begin
            sr_seq_q <= 1'b1;
            sr_pgm_q <= 1'b1;
            state_q  <= S_IDLE;
          end
        end
        S_PROG: begin
          if (fault) begin
            sr_pgm_q <= 1'b1;
            state_q  <= S_IDLE;
          end else if (tmr_done) begin
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    status          = '0;
    status[SR_READY] = (state_q != S_PROG);
    status[SR_SEQ]   = sr_seq_q;
    status[SR_PGM]   = sr_pgm_q;
    status[SR_LOCK]  = sr_lock_q;
  end

  p_prog_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_start |=> (!status[SR_READY] && !wr_ready));
  p_window_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && state_q == S_FILL && !in_win) |=>
      (status[SR_SEQ] && status[SR_PGM] && state_q == S_IDLE));
  p_confirm_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && state_q == S_CONFIRM && !confirm_ok) |=>
      (status[SR_SEQ] && status[SR_PGM] && status[SR_READY]));
  p_block_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && state_q == S_FIRST && blk_cross) |=> (state_q == S_IDLE && status[SR_SEQ]));
  p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && state_q == S_IDLE && cmd == CMD_SETUP && supply_lock) |=>
      (status[SR_PGM] && status[SR_LOCK] && state_q == S_IDLE));
  p_fault_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (status[SR_READY] && status[SR_PGM] && !tmr_run));
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status[SR_SEQ]) |->
      $past(clr_status || (hs && state_q == S_IDLE && cmd == CMD_CLEAR)));
  p_write_in_prog_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> (state_q == S_PROG));
endmodule

// File: tb/flash_bufprog_seq_bench.sv
module flash_bufprog_seq_bench;
  localparam int T_CHUNK = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [7:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        supply_lock = 1'b0;
  logic        cell_fault = 1'b0;
  logic        clr_status = 1'b0;
  logic [7:0]  status;
  logic [7:0]  rd_addr = '0;
  logic [15:0] rd_data;

  int errors = 0;
  int checks = 0;
  logic [15:0] shadow [256];
  logic [15:0] dat [32];

  always #4 clk = ~clk;

  flash_bufprog_seq #(.T_CHUNK(T_CHUNK)) u_flash_bufprog_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .supply_lock(supply_lock),
    .cell_fault(cell_fault), .clr_status(clr_status), .status(status),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  function automatic int exp_busy(int start, int n);
    return ((start >> 5) != ((start + n - 1) >> 5)) ? 2 * T_CHUNK : T_CHUNK;
  endfunction

  function automatic bit crosses_blk(int start, int n);
    return ((start >> 7) != ((start + n - 1) >> 7));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic check_array(string req);
    int bad = -1;
    for (int i = 0; i < 256; i++) begin
      rd_addr = 8'(i);
      #0.1;
      if (bad < 0 && rd_data !== shadow[i]) bad = i;
    end
    if (bad >= 0) begin
      rd_addr = 8'(bad);
      #0.1;
      check(1'b0, {req, " array word"}, int'(rd_data), int'(shadow[bad]));
    end else check(1'b1, req, 0, 0);
  endtask

  task automatic measure_busy(output int n);
    n = 0;
    while (!status[7] && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Complete sequence with sequential addresses; returns busy cycles.
  task automatic full_seq(input int blk_a, input int start, input int n, output int busy);
    for (int i = 0; i < n; i++) dat[i] = 16'($urandom);
    bus_wr(8'(blk_a), 16'h00E8);
    bus_wr(8'(blk_a), 16'(n - 1));
    for (int i = 0; i < n; i++) bus_wr(8'(start + i), dat[i]);
    bus_wr(8'(blk_a), 16'h00D0);
    measure_busy(busy);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int busy;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) shadow[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(status == 8'h80, "R1 status", status, 8'h80);
    check(wr_ready == 1'b1, "R1 ready", wr_ready, 1);
    check_array("R1");

    // R2/R3 aligned full buffer
    full_seq(8'h20, 8'h20, 32, busy);
    for (int i = 0; i < 32; i++) shadow[8'h20 + i] = dat[i];
    check(busy == T_CHUNK, "R3 aligned busy", busy, T_CHUNK);
    check(status == 8'h80, "R2 status after program", status, 8'h80);
    check_array("R2 aligned");

    // R3 chunk-crossing start
    full_seq(8'h00, 8'h1C, 8, busy);
    for (int i = 0; i < 8; i++) shadow[8'h1C + i] = dat[i];
    check(busy == 2 * T_CHUNK, "R3 crossing busy", busy, 2 * T_CHUNK);
    check_array("R2 crossing");

    // R2 single word
    full_seq(8'h7F, 8'h45, 1, busy);
    shadow[8'h45] = dat[0];
    check(busy == T_CHUNK, "R3 single busy", busy, T_CHUNK);
    check_array("R2 single");

    // R2/R3/R6 random sequences
    for (int it = 0; it < 24; it++) begin
      int st = int'($urandom_range(0, 255));
      int n  = int'($urandom_range(1, 32));
      int ba = (st & 8'h80) | int'($urandom_range(0, 127));
      if (crosses_blk(st, n)) begin
        bus_wr(8'(ba), 16'h00E8);
        bus_wr(8'(ba), 16'(n - 1));
        bus_wr(8'(st), 16'($urandom));
        check(status == 8'hB0, "R6 block abort", status, 8'hB0);
        check_array("R6 unchanged");
        bus_wr(8'($urandom), 16'h0050);
        check(status == 8'h80, "R9 clear command", status, 8'h80);
      end else begin
        full_seq(ba, st, n, busy);
        for (int i = 0; i < n; i++) shadow[st + i] = dat[i];
        check(busy == exp_busy(st, n), "R3 random busy", busy, exp_busy(st, n));
        check(status == 8'h80, "R2 random status", status, 8'h80);
        check_array("R2 random");
      end
    end

    // R4 out-of-window fill address, then pin clear
    bus_wr(8'h80, 16'h00E8);
    bus_wr(8'h80, 16'h0003);
    bus_wr(8'h90, 16'hAAAA);
    bus_wr(8'h95, 16'hBBBB);
    check(status == 8'hB0, "R4 window error", status, 8'hB0);
    check_array("R4 unchanged");
    clr_status = 1'b1;
    @(negedge clk);
    clr_status = 1'b0;
    check(status == 8'h80, "R9 clear pin", status, 8'h80);

    // R5 bad confirm code
    bus_wr(8'h80, 16'h00E8);
    bus_wr(8'h80, 16'h0001);
    bus_wr(8'hA0, 16'h1111);
    bus_wr(8'hA1, 16'h2222);
    bus_wr(8'h80, 16'h0070);
    check(status == 8'hB0, "R5 bad confirm code", status, 8'hB0);
    check_array("R5 unchanged code");
    bus_wr(8'h00, 16'h0050);
    // R5 confirm to wrong block
    bus_wr(8'h80, 16'h00E8);
    bus_wr(8'h80, 16'h0000);
    bus_wr(8'hA0, 16'h3333);
    bus_wr(8'h10, 16'h00D0);
    check(status == 8'hB0, "R5 wrong block", status, 8'hB0);
    check_array("R5 unchanged block");
    bus_wr(8'h00, 16'h0050);
    check(status == 8'h80, "R9 clear after R5", status, 8'h80);

    // R7 supply lockout
    supply_lock = 1'b1;
    bus_wr(8'h00, 16'h00E8);
    check(status == 8'h98, "R7 lockout status", status, 8'h98);
    supply_lock = 1'b0;
    bus_wr(8'h00, 16'h0000);
    bus_wr(8'h05, 16'h1234);
    bus_wr(8'h00, 16'h00D0);
    check(status == 8'h98, "R7 later writes ignored", status, 8'h98);
    check_array("R7 unchanged");

    // R9 sticky through a successful program
    full_seq(8'h40, 8'h40, 4, busy);
    for (int i = 0; i < 4; i++) shadow[8'h40 + i] = dat[i];
    check(status == 8'h98, "R9 sticky", status, 8'h98);
    check_array("R9 program with flags");
    bus_wr(8'h00, 16'h0050);
    check(status == 8'h80, "R9 clear lockout", status, 8'h80);

    // R8 fault at word 3 of 6
    for (int i = 0; i < 6; i++) dat[i] = 16'($urandom);
    bus_wr(8'h00, 16'h00E8);
    bus_wr(8'h00, 16'h0005);
    for (int i = 0; i < 6; i++) bus_wr(8'(8'h08 + i), dat[i]);
    bus_wr(8'h00, 16'h00D0);
    begin
      int b = 1;
      for (int k = 0; k < 3; k++) begin
        @(posedge clk);
        @(negedge clk);
        if (!status[7]) b++;
      end
      cell_fault = 1'b1;
      @(negedge clk);
      cell_fault = 1'b0;
      check(b == 4 && status == 8'h90, "R8 fault ready/status", int'(status), 8'h90);
    end
    for (int i = 0; i < 3; i++) shadow[8'h08 + i] = dat[i];
    check_array("R8 partial");
    bus_wr(8'h00, 16'h0050);

    // R10 duplicate address and unfilled slot
    bus_wr(8'h60, 16'h00E8);
    bus_wr(8'h60, 16'h0003);
    bus_wr(8'h60, 16'h0A0A);
    bus_wr(8'h61, 16'h0B0B);
    bus_wr(8'h61, 16'h0C0C);
    bus_wr(8'h63, 16'h0D0D);
    bus_wr(8'h60, 16'h00D0);
    measure_busy(busy);
    shadow[8'h60] = 16'h0A0A;
    shadow[8'h61] = 16'h0C0C;
    shadow[8'h63] = 16'h0D0D;
    check(status == 8'h80, "R10 status", status, 8'h80);
    check_array("R10 duplicate/unfilled");

    report();
  end
endmodule